// File: doc/BRIEF.md
# SDRAM Power-Down Controller

This block lives inside an SDRAM controller and owns the clock-enable pin during low-power standby. When the access logic reports that it has nothing to do (`idle_req`) and nothing is in flight (`busy` low), the controller spends one cycle driving NOP with clock enable still high. It then drops clock enable, which puts the memory into power-down. On the cycle it drops clock enable it records whether any bank had a row open. The result is reported on `pd_mode` as either the precharge type (all banks idle) or the active type (some row open).

Power-down ends when the access logic raises `wake_req`, or when a residency timer expires. That timer keeps the memory from sitting unrefreshed for longer than the refresh period minus a safety margin. Exit is one cycle of NOP with clock enable high again. On the cycle after that, `ready` tells the access logic it may issue commands. The FSM has four states. RUN is normal operation. ENTER is the one-cycle NOP before clock enable falls. DOZE is residency with clock enable low. WAKE is the one-cycle NOP exit. The transitions are:

- RUN→ENTER on an idle request.
- ENTER→DOZE when the entry goes ahead.
- ENTER→RUN when the entry is cancelled.
- DOZE→WAKE on a wake request or timer expiry.
- WAKE→RUN always.

Top module: `sdram_pd_ctrl`

## Requirements
- R1: After reset `cke`=1, `cmd_nop`=0, `ready`=1 and `pd_mode`=2'b00.
- R2: In RUN, `idle_req`=1 with `busy`=0 and `wake_req`=0 at a clock edge moves to ENTER: the following cycle shows `cke`=1, `cmd_nop`=1, `ready`=0. If `busy` and `wake_req` remain low at the next edge, `cke` is 0 in the cycle after that.
- R3: `busy`=1 blocks entry. In RUN, an idle request with `busy` high leaves the block in RUN. In ENTER, `busy` high returns it to RUN with `cke` never going low.
- R4: `wake_req`=1 in ENTER cancels the entry and returns to RUN (`ready`=1, `cke`=1). `wake_req` together with `idle_req` in RUN starts no entry.
- R5: While `cke` is 0, `pd_mode` is 2'b10 (active) if any bit of `bank_open` was 1 during the ENTER cycle, and 2'b01 (precharge) if all bits were 0. Outside residency `pd_mode` is 2'b00.
- R6: `cmd_nop` is 1 in every ENTER, DOZE and WAKE cycle, and 0 in RUN.
- R7: `wake_req`=1 at an edge during residency gives one WAKE cycle (`cke`=1, `cmd_nop`=1, `ready`=0, `pd_mode`=00), followed by RUN with `ready`=1.
- R8: Residency lasts at most LIMIT = REFRESH_CYCLES − EXIT_MARGIN cycles. After that an exit is forced, exactly as in R7, even with `wake_req` low.
- R9: While in residency, changes on `bank_open` do not alter `pd_mode`, and `idle_req` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | Access logic asks to enter power-down |
| wake_req | input | 1 | Access logic asks to leave power-down or cancel entry |
| busy | input | 1 | An access is in progress |
| bank_open | input | NUM_BANKS | One bit per bank, 1 when a row is open |
| cke | output | 1 | Clock enable to the memory |
| cmd_nop | output | 1 | Controller must drive NOP on the command bus |
| pd_mode | output | 2 | 00 none, 01 precharge power-down, 10 active power-down |
| ready | output | 1 | Normal commands may be issued |

## Verification
The entry is repeated for all 16 open-bank patterns of a four-bank configuration. This separates the precharge result from the active result, and it shows that the mode is latched rather than followed when the pattern is flipped mid-residency. The wake time is swept from one cycle to beyond the limit. The measured residency must equal the smaller of the wake time and LIMIT, which tells a requested exit apart from a forced one, including the cycle where both coincide. Busy and wake are also raised in the run and entry states, which separates a blocked entry and a cancelled entry from a completed one.

// File: rtl/sdram_pd_pkg.sv
package sdram_pd_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTER = 2'd1,
        ST_DOZE  = 2'd2,
        ST_WAKE  = 2'd3
    } pd_state_t;

    typedef enum logic [1:0] {
        PDM_NONE      = 2'b00,
        PDM_PRECHARGE = 2'b01,
        PDM_ACTIVE    = 2'b10
    } pd_mode_t;

endpackage

// File: rtl/pd_residency_timer.sv
module pd_residency_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expire
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && (cnt == LAST);

    // R8: the count never passes the last residency cycle
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/pd_mode_capture.sv
module pd_mode_capture
    import sdram_pd_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic                 show,
    input  logic [NUM_BANKS-1:0] bank_open,
    output logic [1:0]           mode
);
    pd_mode_t mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= PDM_NONE;
        end else if (capture) begin
            mode_q <= (|bank_open) ? PDM_ACTIVE : PDM_PRECHARGE;
        end
    end

    assign mode = show ? mode_q : PDM_NONE;

    // R9: the latched type holds for the whole residency
    a_r9_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (show && $past(show)) |-> $stable(mode));

endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
    import sdram_pd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_req,
    input  logic wake_req,
    input  logic busy,
    input  logic expire,
    output logic capture,
    output logic timer_clear,
    output logic in_doze,
    output logic cke,
    output logic cmd_nop,
    output logic ready
);
    pd_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (idle_req && !busy && !wake_req) state_nx = ST_ENTER;
            ST_ENTER: state_nx = (busy || wake_req) ? ST_RUN : ST_DOZE;
            ST_DOZE:  if (wake_req || expire) state_nx = ST_WAKE;
            ST_WAKE:  state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        cke         = 1'b1;
        cmd_nop     = 1'b1;
        ready       = 1'b0;
        capture     = 1'b0;
        timer_clear = 1'b0;
        in_doze     = 1'b0;
        unique case (state)
            ST_RUN: begin
                cmd_nop = 1'b0;
                ready   = 1'b1;
            end
            ST_ENTER: begin
                capture     = 1'b1;
                timer_clear = 1'b1;
            end
            ST_DOZE: begin
                cke     = 1'b0;
                in_doze = 1'b1;
            end
            ST_WAKE: ;
        endcase
    end

    // R6: clock enable is only ever low under a NOP
    a_r6_nop_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> cmd_nop);
    // R3: clock enable falls only after a cycle without busy or wake
    a_r3_entry_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(!busy && !wake_req));
    // R7: exit cycle is a NOP, and ready follows one cycle later
    a_r7_exit_nop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (cmd_nop && !ready));
    a_r7_ready_after: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |=> (ready && !cmd_nop));
    // R2: ready implies normal operation with clock enable high
    a_r2_ready_run: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cke && !cmd_nop));

endmodule

// File: rtl/sdram_pd_ctrl.sv
module sdram_pd_ctrl
    import sdram_pd_pkg::*;
#(
    parameter int NUM_BANKS      = 4,
    parameter int REFRESH_CYCLES = 6_400_000,
    parameter int EXIT_MARGIN    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 idle_req,
    input  logic                 wake_req,
    input  logic                 busy,
    input  logic [NUM_BANKS-1:0] bank_open,
    output logic                 cke,
    output logic                 cmd_nop,
    output logic [1:0]           pd_mode,
    output logic                 ready
);
    localparam int LIMIT = REFRESH_CYCLES - EXIT_MARGIN;

    logic capture, timer_clear, in_doze, expire;

    pd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_req    (idle_req),
        .wake_req    (wake_req),
        .busy        (busy),
        .expire      (expire),
        .capture     (capture),
        .timer_clear (timer_clear),
        .in_doze     (in_doze),
        .cke         (cke),
        .cmd_nop     (cmd_nop),
        .ready       (ready)
    );

    pd_residency_timer #(.LIMIT(LIMIT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (timer_clear),
        .run    (in_doze),
        .expire (expire)
    );

    pd_mode_capture #(.NUM_BANKS(NUM_BANKS)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .show      (in_doze),
        .bank_open (bank_open),
        .mode      (pd_mode)
    );

    // R5: mode reported on entry matches the open-bank pattern of the entry cycle
    a_r5_mode_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (pd_mode == ($past(|bank_open) ? PDM_ACTIVE : PDM_PRECHARGE)));
    // R5: no mode is reported while clock enable is high
    a_r5_mode_none: assert property (@(posedge clk) disable iff (!rst_n)
        cke |-> (pd_mode == PDM_NONE));

endmodule

// File: tb/sdram_pd_ctrl_test.sv
module sdram_pd_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int REF = 20;
    localparam int MARGIN = 4;
    localparam int LIM = REF - MARGIN;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idle_req = 1'b0, wake_req = 1'b0, busy = 1'b0;
    logic [NB-1:0] bank_open = '0;
    logic cke, cmd_nop, ready;
    logic [1:0] pd_mode;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_pd_ctrl #(.NUM_BANKS(NB), .REFRESH_CYCLES(REF), .EXIT_MARGIN(MARGIN)) uut (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .wake_req(wake_req),
        .busy(busy), .bank_open(bank_open), .cke(cke), .cmd_nop(cmd_nop),
        .pd_mode(pd_mode), .ready(ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // packed view of outputs: {cke, cmd_nop, ready, pd_mode}
    function automatic int outs();
        return {cke, cmd_nop, ready, pd_mode};
    endfunction

    localparam int O_RUN   = 5'b10100;
    localparam int O_ENTER = 5'b11000;
    localparam int O_WAKE  = 5'b11000;

    task automatic enter();
        idle_req = 1'b1;
        tick();
        idle_req = 1'b0;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #3;
        chk("R1 reset outputs", outs(), O_RUN);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1 after reset release", outs(), O_RUN);

        // R5 R9 R2 R6 R7: every open-bank pattern
        for (int p = 0; p < (1 << NB); p++) begin
            bank_open = NB'(p);
            idle_req = 1'b1;
            tick();
            chk("R2 R6 enter cycle", outs(), O_ENTER);
            idle_req = 1'b0;
            tick();
            chk("R5 mode on entry", outs(), {3'b010, (p != 0) ? 2'b10 : 2'b01});
            bank_open = ~NB'(p);
            idle_req = 1'b1;
            tick();
            chk("R9 mode latched, idle ignored", outs(), {3'b010, (p != 0) ? 2'b10 : 2'b01});
            idle_req = 1'b0;
            wake_req = 1'b1;
            tick();
            chk("R7 R6 wake cycle", outs(), O_WAKE);
            wake_req = 1'b0;
            bank_open = '0;
            tick();
            chk("R7 ready after wake", outs(), O_RUN);
        end

        // R8 R7: residency length sweep
        for (int w = 1; w <= LIM + 2; w++) begin
            int n;
            enter();
            n = 1;
            for (int k = 0; k < LIM + 5; k++) begin
                if (n >= w) wake_req = 1'b1;
                tick();
                if (cke) break;
                n++;
            end
            wake_req = 1'b0;
            chk("R8 residency cycles", n, (w < LIM) ? w : LIM);
            chk("R8 exit is NOP", outs(), O_WAKE);
            tick();
            chk("R8 ready after exit", outs(), O_RUN);
        end

        // R3: busy blocks entry in RUN
        busy = 1'b1;
        idle_req = 1'b1;
        tick();
        chk("R3 busy blocks entry", outs(), O_RUN);
        tick();
        chk("R3 busy still blocks", outs(), O_RUN);
        busy = 1'b0;
        tick();
        chk("R3 entry once busy drops", outs(), O_ENTER);
        idle_req = 1'b0;
        busy = 1'b1;
        tick();
        chk("R3 busy cancels entry", outs(), O_RUN);
        busy = 1'b0;
        tick();
        chk("R3 no late entry", outs(), O_RUN);

        // R4: wake cancels pending entry; wake with idle starts nothing
        idle_req = 1'b1;
        tick();
        chk("R4 pending", outs(), O_ENTER);
        idle_req = 1'b0;
        wake_req = 1'b1;
        tick();
        chk("R4 wake cancels entry", outs(), O_RUN);
        idle_req = 1'b1;
        tick();
        chk("R4 idle with wake ignored", outs(), O_RUN);
        idle_req = 1'b0;
        wake_req = 1'b0;
        tick();
        chk("R4 stays in run", outs(), O_RUN);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule